// File: doc/BRIEF.md
# Banked Load/Store Data Manipulator

This block sits between a data memory and a combinational compute array. The memory holds 256 words of 24 bits and is spread over eight interleaved banks, so any eight consecutive addresses fall in eight different banks. A load command reads those eight words in a single cycle. It then steers them through eight per-field multiplexers into the eight fields of the launch register. A store command does the reverse: it steers the eight fields of the result register into eight consecutive addresses, all in one cycle.

Each command names a pointer register, a stride register and an entry of a routing table. Loads and stores have separate tables. An entry holds one 3-bit lane select per destination and an 8-bit enable mask. A lane is an offset from the pointer, so a routing entry works the same at any start address, aligned or not. After each command the pointer register advances by the stride register.

A programmable need mask names the launch fields that a computation requires. Fields written by successive loads are gathered into a filled set. The load that completes the need mask raises a one-cycle launch pulse and empties the set. Irregular layouts are therefore handled by a series of partial loads that end in an automatic launch.

Top module: `bank_manip`

## Requirements
- R1: After reset, `launch_data` is all zero, `launch_fire` is low, all eight address registers are zero, every table entry has an all-zero mask, the filled set is empty and the need mask is all ones.
- R2: A load whose pointer register holds P reads addresses P..P+7 modulo 256 in one command. Address a lives in bank a mod 8 at row a div 8. Any P is allowed, including unaligned values and values that wrap past 255.
- R3: In a load, field f (bits [24f+23:24f] of `launch_data`) takes the word at address P+s, where s is the 3-bit select at bits [3f+2:3f] of the load entry. This happens only when bit f of the entry's mask is set. Fields whose mask bit is clear keep their value, and no field changes in a cycle without a load. The new value is visible after the clock edge on which `ld_go` is sampled.
- R4: The pointer register of a load or store becomes (pointer + stride) mod 256 after the command. When both operands name the same register, its value doubles.
- R5: In a store, address P+k receives result field s (bits [24s+23:24s] of `res_data`), where s is the 3-bit select at bits [3k+2:3k] of the store entry. This happens only when bit k of that entry's mask is set. All other addresses are left untouched.
- R6: Fields written by loads gather in the filled set. The cycle after a load that makes the filled set together with that load's mask cover the need mask, `launch_fire` is high for exactly one cycle and the filled set is emptied. A load that leaves the need mask uncovered raises no pulse.
- R7: Writing the need mask through `cfg_need_we` replaces it and empties the filled set.
- R8: A load and a store may be issued in the same cycle. The load sees the memory contents from before that store, and later loads see the stored data.
- R9: When several updates hit the same address register in one cycle, the store update wins over the load update, and both win over a configuration write.
- R10: The load table and the store table are separate, with four entries each. `cfg_tbl_store` chooses the table and `cfg_tbl_idx` the entry. A write changes only that one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_reg_we | input | 1 | Write enable for an address register |
| cfg_reg_idx | input | 3 | Address register to write |
| cfg_reg_data | input | 8 | Value written to the address register |
| cfg_tbl_we | input | 1 | Write enable for a routing table entry |
| cfg_tbl_store | input | 1 | 1 selects the store table, 0 the load table |
| cfg_tbl_idx | input | 2 | Table entry to write |
| cfg_tbl_sel | input | 24 | Eight 3-bit lane/field selects |
| cfg_tbl_mask | input | 8 | Enable mask of the entry |
| cfg_need_we | input | 1 | Write enable for the need mask |
| cfg_need_mask | input | 8 | Launch fields required before firing |
| ld_go | input | 1 | Issue a load this cycle |
| ld_ptr | input | 3 | Pointer register of the load |
| ld_stride | input | 3 | Stride register of the load |
| ld_entry | input | 2 | Load table entry |
| st_go | input | 1 | Issue a store this cycle |
| st_ptr | input | 3 | Pointer register of the store |
| st_stride | input | 3 | Stride register of the store |
| st_entry | input | 2 | Store table entry |
| res_data | input | 192 | Result register, eight 24-bit fields |
| launch_data | output | 192 | Launch register, eight 24-bit fields |
| launch_fire | output | 1 | One-cycle pulse: the launch register is ready |

## Verification
The hardest cases to reach are those that need the memory in a known state and two commands colliding in one cycle. Examples are a load and a store on the same eight addresses, or a load and a store updating the same pointer register. The bench first fills all 256 words through full-mask stores with a computed pattern. It then issues simultaneous load/store commands with chosen register overlaps and checks the result through follow-up loads with zero stride. Runs that wrap past the top of memory come from pointer values near 255 in the vector table.

// File: rtl/bank_manip_pkg.sv
package bank_manip_pkg;
  localparam int NB    = 8;
  localparam int DW    = 24;
  localparam int WORDS = 256;
  localparam int NREG  = 8;
  localparam int NENT  = 4;
  localparam int LW    = $clog2(NB);
  localparam int AW    = $clog2(WORDS);
  localparam int RW    = AW - LW;
  localparam int ROWS  = WORDS / NB;
  localparam int RIW   = $clog2(NREG);
  localparam int EW    = $clog2(NENT);
  localparam int SELW  = NB * LW;

  function automatic logic [AW-1:0] lane_addr(input logic [AW-1:0] base, input logic [LW-1:0] k);
    return base + AW'(k);
  endfunction

  function automatic logic [LW-1:0] bank_of(input logic [AW-1:0] a);
    return a[LW-1:0];
  endfunction

  function automatic logic [RW-1:0] row_of(input logic [AW-1:0] a);
    return a[AW-1:LW];
  endfunction

  function automatic logic [LW-1:0] lane_of_bank(input logic [AW-1:0] base, input logic [LW-1:0] b);
    return b - base[LW-1:0];
  endfunction

  function automatic logic covers(input logic [NB-1:0] have, input logic [NB-1:0] need);
    return (have & need) == need;
  endfunction
endpackage

// File: rtl/bank_manip_regs.sv
module bank_manip_regs
  import bank_manip_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [RIW-1:0] cfg_idx,
  input  logic [AW-1:0]  cfg_data,
  input  logic           ld_upd,
  input  logic [RIW-1:0] ld_p,
  input  logic [RIW-1:0] ld_s,
  input  logic           st_upd,
  input  logic [RIW-1:0] st_p,
  input  logic [RIW-1:0] st_s,
  output logic [AW-1:0]  ld_base,
  output logic [AW-1:0]  ld_step,
  output logic [AW-1:0]  st_base,
  output logic [AW-1:0]  st_step
);
  logic [AW-1:0] rf [NREG];

  assign ld_base = rf[ld_p];
  assign ld_step = rf[ld_s];
  assign st_base = rf[st_p];
  assign st_step = rf[st_s];

  // later statements win: store > load > configuration write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      if (cfg_we) rf[cfg_idx] <= cfg_data;
      if (ld_upd) rf[ld_p]    <= ld_base + ld_step;
      if (st_upd) rf[st_p]    <= st_base + st_step;
    end
  end
endmodule

// File: rtl/bank_manip_table.sv
module bank_manip_table
  import bank_manip_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [EW-1:0]   wr_idx,
  input  logic [SELW-1:0] wr_sel,
  input  logic [NB-1:0]   wr_mask,
  input  logic [EW-1:0]   rd_idx,
  output logic [SELW-1:0] rd_sel,
  output logic [NB-1:0]   rd_mask
);
  logic [SELW-1:0] sel_q  [NENT];
  logic [NB-1:0]   mask_q [NENT];

  assign rd_sel  = sel_q[rd_idx];
  assign rd_mask = mask_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < NENT; e++) begin
        sel_q[e]  <= '0;
        mask_q[e] <= '0;
      end
    end else if (we) begin
      sel_q[wr_idx]  <= wr_sel;
      mask_q[wr_idx] <= wr_mask;
    end
  end
endmodule

// File: rtl/bank_manip_banks.sv
module bank_manip_banks
  import bank_manip_pkg::*;
(
  input  logic                   clk,
  input  logic [NB-1:0][RW-1:0]  rd_row,
  output logic [NB-1:0][DW-1:0]  rd_data,
  input  logic [NB-1:0]          we,
  input  logic [NB-1:0][RW-1:0]  wr_row,
  input  logic [NB-1:0][DW-1:0]  wr_data
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [DW-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
      if (we[b]) mem[wr_row[b]] <= wr_data[b];
    end

    assign rd_data[b] = mem[rd_row[b]];
  end
endmodule

// File: rtl/bank_manip_launch.sv
module bank_manip_launch
  import bank_manip_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld_go,
  input  logic [NB-1:0]         ld_mask,
  input  logic [NB-1:0][DW-1:0] ld_vals,
  input  logic                  need_we,
  input  logic [NB-1:0]         need_mask,
  output logic [NB-1:0][DW-1:0] fields,
  output logic                  fire,
  output logic [NB-1:0]         fill_set
);
  logic [NB-1:0] need_q;
  logic          complete;

  assign complete = covers(fill_set | ld_mask, need_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fields   <= '0;
      fire     <= 1'b0;
      fill_set <= '0;
      need_q   <= '1;
    end else begin
      fire <= 1'b0;
      if (ld_go) begin
        for (int f = 0; f < NB; f++)
          if (ld_mask[f]) fields[f] <= ld_vals[f];
        if (complete) begin
          fire     <= 1'b1;
          fill_set <= '0;
        end else begin
          fill_set <= fill_set | ld_mask;
        end
      end
      if (need_we) begin
        need_q   <= need_mask;
        fill_set <= '0;
      end
    end
  end
endmodule

// File: rtl/bank_manip.sv
module bank_manip
  import bank_manip_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_reg_we,
  input  logic [RIW-1:0]   cfg_reg_idx,
  input  logic [AW-1:0]    cfg_reg_data,
  input  logic             cfg_tbl_we,
  input  logic             cfg_tbl_store,
  input  logic [EW-1:0]    cfg_tbl_idx,
  input  logic [SELW-1:0]  cfg_tbl_sel,
  input  logic [NB-1:0]    cfg_tbl_mask,
  input  logic             cfg_need_we,
  input  logic [NB-1:0]    cfg_need_mask,
  input  logic             ld_go,
  input  logic [RIW-1:0]   ld_ptr,
  input  logic [RIW-1:0]   ld_stride,
  input  logic [EW-1:0]    ld_entry,
  input  logic             st_go,
  input  logic [RIW-1:0]   st_ptr,
  input  logic [RIW-1:0]   st_stride,
  input  logic [EW-1:0]    st_entry,
  input  logic [NB*DW-1:0] res_data,
  output logic [NB*DW-1:0] launch_data,
  output logic             launch_fire
);
  logic [AW-1:0] ld_base, ld_step, st_base, st_step;
  logic [SELW-1:0] ld_sel_w, st_sel_w;
  logic [NB-1:0]   ld_mask_w, st_mask_w;

  logic [NB-1:0][RW-1:0] bank_rd_row, bank_wr_row;
  logic [NB-1:0][DW-1:0] bank_rd_data, bank_wr_data;
  logic [NB-1:0]         bank_we;

  logic [NB-1:0][DW-1:0] lane_data;
  logic [NB-1:0][DW-1:0] field_val;
  logic [NB-1:0][DW-1:0] res_f;
  logic [NB-1:0][DW-1:0] fields_q;
  logic [NB-1:0]         fill_set;

  assign res_f       = res_data;
  assign launch_data = fields_q;

  bank_manip_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_reg_we), .cfg_idx(cfg_reg_idx), .cfg_data(cfg_reg_data),
    .ld_upd(ld_go), .ld_p(ld_ptr), .ld_s(ld_stride),
    .st_upd(st_go), .st_p(st_ptr), .st_s(st_stride),
    .ld_base(ld_base), .ld_step(ld_step), .st_base(st_base), .st_step(st_step)
  );

  bank_manip_table u_ld_tbl (
    .clk(clk), .rst_n(rst_n),
    .we(cfg_tbl_we & ~cfg_tbl_store), .wr_idx(cfg_tbl_idx),
    .wr_sel(cfg_tbl_sel), .wr_mask(cfg_tbl_mask),
    .rd_idx(ld_entry), .rd_sel(ld_sel_w), .rd_mask(ld_mask_w)
  );

  bank_manip_table u_st_tbl (
    .clk(clk), .rst_n(rst_n),
    .we(cfg_tbl_we & cfg_tbl_store), .wr_idx(cfg_tbl_idx),
    .wr_sel(cfg_tbl_sel), .wr_mask(cfg_tbl_mask),
    .rd_idx(st_entry), .rd_sel(st_sel_w), .rd_mask(st_mask_w)
  );

  bank_manip_banks u_banks (
    .clk(clk),
    .rd_row(bank_rd_row), .rd_data(bank_rd_data),
    .we(bank_we), .wr_row(bank_wr_row), .wr_data(bank_wr_data)
  );

  // read side: bank -> row, bank -> lane, lane -> field
  always_comb begin
    for (int b = 0; b < NB; b++)
      bank_rd_row[b] = row_of(lane_addr(ld_base, lane_of_bank(ld_base, LW'(b))));
    for (int k = 0; k < NB; k++)
      lane_data[k] = bank_rd_data[bank_of(lane_addr(ld_base, LW'(k)))];
    for (int f = 0; f < NB; f++)
      field_val[f] = lane_data[ld_sel_w[f*LW +: LW]];
  end

  // write side: each bank finds its lane, the lane picks a result field
  always_comb begin
    for (int b = 0; b < NB; b++) begin
      logic [LW-1:0] k;
      k               = lane_of_bank(st_base, LW'(b));
      bank_we[b]      = st_go & st_mask_w[k];
      bank_wr_row[b]  = row_of(lane_addr(st_base, k));
      bank_wr_data[b] = res_f[st_sel_w[k*LW +: LW]];
    end
  end

  bank_manip_launch u_launch (
    .clk(clk), .rst_n(rst_n),
    .ld_go(ld_go), .ld_mask(ld_mask_w), .ld_vals(field_val),
    .need_we(cfg_need_we), .need_mask(cfg_need_mask),
    .fields(fields_q), .fire(launch_fire), .fill_set(fill_set)
  );
endmodule

// File: rtl/bank_manip_chk.sv
module bank_manip_chk
  import bank_manip_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ld_go,
  input logic             st_go,
  input logic             launch_fire,
  input logic [NB*DW-1:0] launch_data,
  input logic [NB-1:0]    fill_set,
  input logic [NB-1:0]    bank_we,
  input logic [NB-1:0]    st_mask_w
);
  AST_FIRE_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    launch_fire |-> $past(ld_go)); // R6
  AST_FIRE_EMPTIES_SET: assert property (@(posedge clk) disable iff (!rst_n)
    launch_fire |-> (fill_set == '0)); // R6
  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_go |=> $stable(launch_data)); // R3
  AST_WRITE_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_we) |-> st_go); // R5
  AST_WRITE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    st_go |-> ($countones(bank_we) == $countones(st_mask_w))); // R5
endmodule

bind bank_manip bank_manip_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ld_go(ld_go), .st_go(st_go),
  .launch_fire(launch_fire), .launch_data(launch_data),
  .fill_set(fill_set), .bank_we(bank_we), .st_mask_w(st_mask_w)
);

// File: tb/bank_manip_tb_top.sv
module bank_manip_tb_top;
  localparam int CLK_P = 10;
  localparam logic [23:0] SEL_ID  = 24'hFAC688; // field f <- lane f
  localparam logic [23:0] SEL_REV = 24'h053977; // field f <- lane 7-f
  localparam logic [23:0] SEL_L3  = 24'h6DB6DB; // every field <- lane 3
  // {start, stride, select word, mask}
  localparam logic [47:0] VEC [6] = '{
    {8'd0,   8'd8,   SEL_ID,  8'hFF},
    {8'd13,  8'd5,   SEL_ID,  8'hFF},
    {8'd252, 8'd9,   SEL_REV, 8'hFF},
    {8'd100, 8'd250, SEL_L3,  8'h5A},
    {8'd77,  8'd1,   SEL_REV, 8'hA5},
    {8'd255, 8'd255, 24'h1C8FA3, 8'h3C}
  };

  logic clk = 0, rst_n = 0;
  logic cfg_reg_we = 0; logic [2:0] cfg_reg_idx = 0; logic [7:0] cfg_reg_data = 0;
  logic cfg_tbl_we = 0, cfg_tbl_store = 0; logic [1:0] cfg_tbl_idx = 0;
  logic [23:0] cfg_tbl_sel = 0; logic [7:0] cfg_tbl_mask = 0;
  logic cfg_need_we = 0; logic [7:0] cfg_need_mask = 0;
  logic ld_go = 0, st_go = 0;
  logic [2:0] ld_ptr = 0, ld_stride = 0, st_ptr = 0, st_stride = 0;
  logic [1:0] ld_entry = 0, st_entry = 0;
  logic [191:0] res_data = 0;
  logic [191:0] launch_data;
  logic launch_fire;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [23:0] mem_m [256];
  logic [23:0] launch_m [8];
  logic [23:0] res_m [8];
  logic [7:0]  reg_m [8];
  logic [23:0] lsel_m [4], ssel_m [4];
  logic [7:0]  lmask_m [4], smask_m [4];
  logic [7:0]  need_m, fill_m;
  logic        fire_m;

  always #(CLK_P/2) clk = ~clk;

  bank_manip dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_reg_we(cfg_reg_we), .cfg_reg_idx(cfg_reg_idx), .cfg_reg_data(cfg_reg_data),
    .cfg_tbl_we(cfg_tbl_we), .cfg_tbl_store(cfg_tbl_store), .cfg_tbl_idx(cfg_tbl_idx),
    .cfg_tbl_sel(cfg_tbl_sel), .cfg_tbl_mask(cfg_tbl_mask),
    .cfg_need_we(cfg_need_we), .cfg_need_mask(cfg_need_mask),
    .ld_go(ld_go), .ld_ptr(ld_ptr), .ld_stride(ld_stride), .ld_entry(ld_entry),
    .st_go(st_go), .st_ptr(st_ptr), .st_stride(st_stride), .st_entry(st_entry),
    .res_data(res_data), .launch_data(launch_data), .launch_fire(launch_fire)
  );

  function automatic logic [23:0] pat(input int a, input int salt);
    return {8'(a ^ 8'h3C ^ salt), 8'(a * 7 + salt), 8'(a)};
  endfunction

  task automatic chk(input string req, input logic [191:0] act, input logic [191:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [191:0] launch_exp();
    logic [191:0] v;
    for (int f = 0; f < 8; f++) v[f*24 +: 24] = launch_m[f];
    return v;
  endfunction

  task automatic check_out(input string req);
    chk({req, " launch"}, launch_data, launch_exp());
    chk({req, " fire"}, {191'd0, launch_fire}, {191'd0, fire_m});
  endtask

  task automatic set_res(input int salt);
    for (int f = 0; f < 8; f++) begin
      res_m[f] = pat(f * 31 + salt, salt);
      res_data[f*24 +: 24] = res_m[f];
    end
  endtask

  task automatic prog_reg(input int idx, input logic [7:0] val);
    cfg_reg_we = 1; cfg_reg_idx = 3'(idx); cfg_reg_data = val;
    @(negedge clk); cfg_reg_we = 0;
    reg_m[idx] = val; fire_m = 0;
  endtask

  task automatic prog_tbl(input bit st, input int idx, input logic [23:0] sel, input logic [7:0] m);
    cfg_tbl_we = 1; cfg_tbl_store = st; cfg_tbl_idx = 2'(idx); cfg_tbl_sel = sel; cfg_tbl_mask = m;
    @(negedge clk); cfg_tbl_we = 0;
    if (st) begin ssel_m[idx] = sel; smask_m[idx] = m; end
    else    begin lsel_m[idx] = sel; lmask_m[idx] = m; end
    fire_m = 0;
  endtask

  task automatic prog_need(input logic [7:0] m);
    cfg_need_we = 1; cfg_need_mask = m;
    @(negedge clk); cfg_need_we = 0;
    need_m = m; fill_m = 0; fire_m = 0;
  endtask

  // one command cycle; model reads old state first, then applies updates
  task automatic cmd(input bit lg, input int lp, input int ls, input int le,
                     input bit sg, input int sp, input int ss, input int se);
    logic [7:0] old_r [8];
    ld_go = lg; ld_ptr = 3'(lp); ld_stride = 3'(ls); ld_entry = 2'(le);
    st_go = sg; st_ptr = 3'(sp); st_stride = 3'(ss); st_entry = 2'(se);
    old_r = reg_m;
    fire_m = 0;
    if (lg) begin
      for (int f = 0; f < 8; f++)
        if (lmask_m[le][f]) launch_m[f] = mem_m[8'(old_r[lp] + lsel_m[le][f*3 +: 3])];
      if (((fill_m | lmask_m[le]) & need_m) == need_m) begin fire_m = 1; fill_m = 0; end
      else fill_m = fill_m | lmask_m[le];
      reg_m[lp] = old_r[lp] + old_r[ls];
    end
    if (sg) begin
      for (int k = 0; k < 8; k++)
        if (smask_m[se][k]) mem_m[8'(old_r[sp] + k)] = res_m[ssel_m[se][k*3 +: 3]];
      reg_m[sp] = old_r[sp] + old_r[ss];
    end
    @(negedge clk);
    ld_go = 0; st_go = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin launch_m[i] = 0; reg_m[i] = 0; end
    for (int i = 0; i < 4; i++) begin lsel_m[i] = 0; ssel_m[i] = 0; lmask_m[i] = 0; smask_m[i] = 0; end
    for (int i = 0; i < 256; i++) mem_m[i] = 0;
    need_m = 8'hFF; fill_m = 0; fire_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_out("R1 reset");

    // fill memory: reg0 = 0 after reset (R1), reg7 = 8, store entry 0 identity
    prog_reg(7, 8'd8);
    prog_tbl(1, 0, SEL_ID, 8'hFF);
    for (int i = 0; i < 32; i++) begin
      for (int f = 0; f < 8; f++) begin
        res_m[f] = pat(i * 8 + f, 0);
        res_data[f*24 +: 24] = res_m[f];
      end
      cmd(0, 0, 0, 0, 1, 0, 7, 0);
    end
    // unprogrammed load entry 3 has a zero mask: nothing changes, no fire (R1, R10)
    cmd(1, 0, 7, 3, 0, 0, 0, 0);
    check_out("R1 R10 empty entry");

    // vector table: R2 R3 R4 R6
    for (int v = 0; v < 6; v++) begin
      prog_reg(1, VEC[v][47:40]);
      prog_reg(2, VEC[v][39:32]);
      prog_tbl(0, 1, VEC[v][31:8], VEC[v][7:0]);
      prog_need(VEC[v][7:0]);
      cmd(1, 1, 2, 1, 0, 0, 0, 0);
      check_out("R2 R3 first load");
      cmd(1, 1, 2, 1, 0, 0, 0, 0);
      check_out("R4 advanced load");
    end

    // R6: accumulation over two partial loads
    prog_need(8'hFF);
    prog_reg(1, 8'd40); prog_reg(6, 8'd0);
    prog_tbl(0, 0, SEL_REV, 8'h0F);
    prog_tbl(0, 2, SEL_ID, 8'hF0);
    cmd(1, 1, 6, 0, 0, 0, 0, 0);
    check_out("R6 partial no fire");
    cmd(1, 1, 6, 2, 0, 0, 0, 0);
    check_out("R6 completing load fires");
    @(negedge clk);
    chk("R6 pulse one cycle", {191'd0, launch_fire}, 192'd0);

    // R7: writing need mask empties the filled set
    prog_need(8'h03);
    prog_tbl(0, 0, SEL_ID, 8'h01);
    prog_tbl(0, 2, SEL_ID, 8'h02);
    cmd(1, 1, 6, 0, 0, 0, 0, 0);
    prog_need(8'h03);
    cmd(1, 1, 6, 2, 0, 0, 0, 0);
    check_out("R7 set cleared, no fire");
    cmd(1, 1, 6, 0, 0, 0, 0, 0);
    check_out("R7 fire after refill");

    // R8: load and store on the same addresses in one cycle
    prog_need(8'hFF);
    prog_tbl(0, 0, SEL_ID, 8'hFF);
    prog_reg(3, 8'd43);
    set_res(91);
    cmd(1, 1, 6, 0, 1, 3, 6, 0);
    check_out("R8 load sees old data");
    cmd(1, 1, 6, 0, 0, 0, 0, 0);
    check_out("R8 later load sees store");

    // R5: partial store mask with reversed routing
    prog_tbl(1, 1, SEL_REV, 8'h21);
    prog_reg(5, 8'd200);
    set_res(17);
    cmd(0, 0, 0, 0, 1, 5, 6, 1);
    cmd(1, 5, 6, 0, 0, 0, 0, 0);
    check_out("R5 masked store");

    // R9: store update beats load update on the same register
    prog_reg(3, 8'd10); prog_reg(4, 8'd1); prog_reg(5, 8'd2);
    cmd(1, 3, 4, 0, 1, 3, 5, 2);
    cmd(1, 3, 6, 0, 0, 0, 0, 0);
    check_out("R9 store wins");

    // R4: pointer and stride in the same register double it
    prog_reg(4, 8'd30);
    cmd(1, 4, 4, 0, 0, 0, 0, 0);
    cmd(1, 4, 6, 0, 0, 0, 0, 0);
    check_out("R4 doubled pointer");

    // R10: load entries are distinct
    prog_tbl(0, 3, SEL_L3, 8'hFF);
    cmd(1, 4, 6, 3, 0, 0, 0, 0);
    check_out("R10 entry 3");
    cmd(1, 4, 6, 0, 0, 0, 0, 0);
    check_out("R10 entry 0 unchanged");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule